// File: doc/BRIEF.md
# Fault Injection Trigger Sequencer

This block paces a repeating fault-injection experiment against a target device. Every experiment holds the target in reset for a set number of clocks, releases it, and then lets a fixed blanking interval pass so that early activity on a watched bus line is skipped. After blanking, the first falling edge on the watched line raises a trigger and opens a bounded attack window. Inside that window the block fires exactly one single-cycle glitch strobe. The strobe lands at a pseudo-random offset, and a pseudo-random power code goes with it.

If the watched line never falls within a timeout after blanking, the experiment is abandoned and flagged. A done pulse closes every experiment. While the run input stays high, the next experiment starts on the following clock. With the default parameters at 100 MHz, the reset hold is 1 ms, blanking is 17 ms, the window is 10 µs and the timeout is 80 ms. The worst-case experiment therefore stays near 100 ms, which gives about ten attempts per second.

Top module: `fi_trigger_seq`

## Requirements
- R1: After synchronous reset, `tgt_rst_n` is 1, `trig`, `glitch`, `done` and `tmo` are 0, `pwr_code` is 0, and all of them stay that way while `run` is low.
- R2: With `run` high, an experiment begins by driving `tgt_rst_n` low for exactly HOLD_CYC clock cycles and then high again.
- R3: For BLANK_CYC cycles after `tgt_rst_n` returns high, falling edges on `mon_line` are ignored. A line that is still low when arming begins gives no trigger.
- R4: After blanking, the first falling edge of `mon_line` raises `trig` on the third rising clock edge after the line falls (two synchronizer flops plus the edge stage).
- R5: `trig` stays high for exactly WIN_CYC cycles. Further edges on `mon_line` inside the window have no effect.
- R6: Each window carries exactly one single-cycle `glitch` pulse, in window cycle off+1 (the first trig cycle is 0), where off = (v * (WIN_CYC-1)) >> 16 and v is the random value of that window.
- R7: v comes from a 16-bit shift register that starts at SEED (default 16'hACE1). Its next value is {v[14:0], v[15]^v[13]^v[12]^v[10]}. The first window uses SEED, and the register steps once per opened window only.
- R8: `pwr_code` = 10 + ((v[6:0] * 91) >> 7), which always lies in 10..100. It changes on the first window cycle and holds until the next window opens.
- R9: If no falling edge comes within TMO_CYC cycles of arming, `done` and `tmo` pulse together for one cycle, and neither `trig` nor `glitch` rises.
- R10: `done` is a one-cycle pulse in the cycle after `trig` falls. If `run` is high then, the next reset hold starts on the following cycle. Otherwise the block goes idle, with `tgt_rst_n` high and no more pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep starting experiments while high |
| mon_line | input | 1 | Asynchronous bus line watched for the arming edge |
| tgt_rst_n | output | 1 | Target reset, low holds the target in reset |
| trig | output | 1 | High for the duration of the attack window |
| glitch | output | 1 | Single-cycle glitch strobe |
| pwr_code | output | 7 | Glitch power code, 10..100 percent |
| done | output | 1 | One-cycle end-of-experiment pulse |
| tmo | output | 1 | One-cycle flag, with done, when arming timed out |

## Verification
The bench counts clocks from its own stimulus. It expects `trig` three cycles after it drops `mon_line`, the glitch in window cycle off+1, `done` in the cycle right after the last trig cycle, and a reset-hold length of HOLD_CYC. Edges are placed on both sides of the blanking boundary and on the last cycle before timeout to pin down R3 and R9. A scoreboard queue carries, for each experiment, the expected timeout flag, offset and power code, computed from the R6 to R8 formulas. A monitor sampling on the falling clock edge pops one entry per `done` and compares the whole window against it.

// File: rtl/fitseq_pkg.sv
package fitseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_BLANK, ST_ARM, ST_WIN, ST_DONE
  } seq_st_t;

  localparam int unsigned RNG_W    = 16;
  localparam int unsigned PWR_W    = 7;
  localparam int unsigned PWR_MIN  = 10;
  localparam int unsigned PWR_SPAN = 91;

  // one step of the 16-bit pseudo-random sequence
  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fitseq_fall.sv
module fitseq_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/fitseq_lfsr.sv
module fitseq_lfsr
  import fitseq_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [RNG_W-1:0] value
);
  localparam logic [RNG_W-1:0] START = (SEED == '0) ? RNG_W'(1) : SEED;

  always_ff @(posedge clk) begin
    if (rst)       value <= START;
    else if (step) value <= rng_step(value);
  end
endmodule

// File: rtl/fitseq_pick.sv
module fitseq_pick
  import fitseq_pkg::*;
#(
  parameter int unsigned WIN_CYC = 1000,
  parameter int unsigned OW      = 10
) (
  input  logic [RNG_W-1:0] v,
  output logic [OW-1:0]    off,
  output logic [PWR_W-1:0] pwr
);
  localparam int unsigned PRW = RNG_W + OW;
  localparam int unsigned PMW = PWR_W + 7;

  logic [PRW-1:0] prod;
  logic [PMW-1:0] pm;

  // scale into 0..WIN_CYC-2 with a multiply and shift, no divider
  assign prod = PRW'(v) * PRW'(WIN_CYC - 1);
  assign off  = OW'(prod >> RNG_W);

  // map 0..127 onto 10..100
  assign pm  = PMW'(v[6:0]) * PMW'(PWR_SPAN);
  assign pwr = PWR_W'(PWR_MIN) + pm[PMW-1:7];
endmodule

// File: rtl/fi_trigger_seq.sv
module fi_trigger_seq
  import fitseq_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 100_000,
  parameter int unsigned BLANK_CYC = 1_700_000,
  parameter int unsigned WIN_CYC   = 1000,
  parameter int unsigned TMO_CYC   = 8_000_000,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [15:0] SEED      = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             mon_line,
  output logic             tgt_rst_n,
  output logic             trig,
  output logic             glitch,
  output logic [PWR_W-1:0] pwr_code,
  output logic             done,
  output logic             tmo
);
  localparam int unsigned MAXC = max2(max2(HOLD_CYC, BLANK_CYC), max2(WIN_CYC, TMO_CYC));
  localparam int unsigned CW   = $clog2(MAXC) + 1;
  localparam int unsigned OW   = $clog2(WIN_CYC);

  seq_st_t          st;
  logic [CW-1:0]    cnt;
  logic [OW-1:0]    off_q;
  logic             fall;
  logic             open_win;
  logic [RNG_W-1:0] rnd;
  logic [OW-1:0]    off_d;
  logic [PWR_W-1:0] pwr_d;

  fitseq_fall #(.STAGES(SYNC_STG)) u_fall (
    .clk (clk), .rst (rst), .din (mon_line), .fall (fall)
  );

  assign open_win = (st == ST_ARM) && fall;

  fitseq_lfsr #(.SEED(SEED)) u_rng (
    .clk (clk), .rst (rst), .step (open_win), .value (rnd)
  );

  fitseq_pick #(.WIN_CYC(WIN_CYC), .OW(OW)) u_pick (
    .v (rnd), .off (off_d), .pwr (pwr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      off_q     <= '0;
      tgt_rst_n <= 1'b1;
      trig      <= 1'b0;
      glitch    <= 1'b0;
      pwr_code  <= '0;
      done      <= 1'b0;
      tmo       <= 1'b0;
    end else begin
      glitch <= 1'b0;
      done   <= 1'b0;
      tmo    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (run) begin
            st        <= ST_HOLD;
            cnt       <= '0;
            tgt_rst_n <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) begin
            st        <= ST_BLANK;
            cnt       <= '0;
            tgt_rst_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BLANK: begin
          if (cnt == CW'(BLANK_CYC - 1)) begin
            st  <= ST_ARM;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ARM: begin
          if (fall) begin
            st       <= ST_WIN;
            cnt      <= '0;
            trig     <= 1'b1;
            off_q    <= off_d;
            pwr_code <= pwr_d;
          end else if (cnt == CW'(TMO_CYC - 1)) begin
            st   <= ST_DONE;
            done <= 1'b1;
            tmo  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WIN: begin
          if (cnt == CW'(off_q)) glitch <= 1'b1;
          if (cnt == CW'(WIN_CYC - 1)) begin
            st   <= ST_DONE;
            trig <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: begin
          cnt <= '0;
          if (run) begin
            st        <= ST_HOLD;
            tgt_rst_n <= 1'b0;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fitseq_checker.sv
module fitseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       tgt_rst_n,
  input logic       trig,
  input logic       glitch,
  input logic       done,
  input logic       tmo,
  input logic [6:0] pwr_code
);
  AST_GLITCH_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    glitch |-> trig);                                                  // R6
  AST_GLITCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    glitch |=> !glitch);                                               // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                   // R10
  AST_TRIG_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(trig) |-> done);                                             // R10
  AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    tmo |-> (done && !trig));                                          // R9
  AST_POWER_RANGE: assert property (@(posedge clk) disable iff (rst)
    trig |-> (pwr_code >= 7'd10 && pwr_code <= 7'd100));               // R8
  AST_POWER_STABLE: assert property (@(posedge clk) disable iff (rst)
    (trig && $past(trig)) |-> $stable(pwr_code));                      // R8
  AST_HOLD_NO_TRIG: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n |-> !trig);                                             // R2
endmodule

bind fi_trigger_seq fitseq_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tgt_rst_n (tgt_rst_n),
  .trig      (trig),
  .glitch    (glitch),
  .done      (done),
  .tmo       (tmo),
  .pwr_code  (pwr_code)
);

// File: tb/sim_fi_trigger_seq.sv
module sim_fi_trigger_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD  = 8;
  localparam int BLANK = 40;
  localparam int WIN   = 20;
  localparam int TMO   = 30;
  localparam int WDOG  = 20000;
  localparam logic [15:0] SEED = 16'hACE1;

  typedef struct {
    bit tmo;
    int off;
    int pw;
  } exp_t;

  logic clk = 1'b0;
  logic rst, run, mon_line;
  logic tgt_rst_n, trig, glitch, done, tmo;
  logic [6:0] pwr_code;

  int n_chk = 0, n_fail = 0, cyc = 0, drop_cyc = 0;
  exp_t q[$];
  logic [15:0] mv = SEED;

  fi_trigger_seq #(
    .HOLD_CYC(HOLD), .BLANK_CYC(BLANK), .WIN_CYC(WIN), .TMO_CYC(TMO),
    .SYNC_STG(2), .SEED(SEED)
  ) u0 (
    .clk(clk), .rst(rst), .run(run), .mon_line(mon_line),
    .tgt_rst_n(tgt_rst_n), .trig(trig), .glitch(glitch),
    .pwr_code(pwr_code), .done(done), .tmo(tmo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // model of the random source and mappings, from R6..R8
  task automatic push_hit();
    exp_t e;
    logic [31:0] pr;
    e.tmo = 1'b0;
    pr    = 32'(mv) * 32'(WIN - 1);
    e.off = int'(pr >> 16);
    e.pw  = 10 + ((int'(mv[6:0]) * 91) >> 7);
    mv    = {mv[14:0], mv[15] ^ mv[13] ^ mv[12] ^ mv[10]};
    q.push_back(e);
  endtask

  task automatic push_tmo();
    exp_t e;
    e.tmo = 1'b1; e.off = 0; e.pw = 0;
    q.push_back(e);
  endtask

  task automatic wait_release();
    @(negedge clk);
    while (tgt_rst_n !== 1'b0) @(negedge clk);
    while (tgt_rst_n !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  // d < 0: no edge at all. low_till_done: keep line low until done.
  task automatic run_exp(input int d, input bit retoggle, input bit hit, input bit low_till_done);
    wait_release();
    if (d < 0) begin
      push_tmo();
      return;
    end
    repeat (d) @(negedge clk);
    mon_line = 1'b0;
    drop_cyc = cyc;
    if (hit) push_hit(); else push_tmo();
    if (low_till_done) begin
      wait_done();
      mon_line = 1'b1;
    end else if (retoggle) begin
      repeat (2) @(negedge clk); mon_line = 1'b1;
      repeat (2) @(negedge clk); mon_line = 1'b0;
      repeat (3) @(negedge clk); mon_line = 1'b1;
    end else begin
      repeat (4) @(negedge clk); mon_line = 1'b1;
    end
  endtask

  // monitor / scoreboard
  int  low_len = 0, win_len = 0, g_cnt = 0, g_pos = -1;
  bit  prev_trig = 1'b0, saw_trig = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!tgt_rst_n) low_len++;
      else if (low_len > 0) begin
        chk(low_len == HOLD, "R2 hold length", low_len, HOLD);
        low_len = 0;
      end
      if (trig) begin
        if (!prev_trig) begin
          chk(cyc == drop_cyc + 3, "R4 trigger latency", cyc - drop_cyc, 3);
          win_len = 0; g_cnt = 0; g_pos = -1;
        end
        saw_trig = 1'b1;
        if (glitch) begin g_cnt++; g_pos = win_len; end
        win_len++;
      end else if (glitch) begin
        chk(1'b0, "R6 glitch outside window", 1, 0);
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(tmo == e.tmo, "R9 timeout flag", int'(tmo), int'(e.tmo));
          if (e.tmo) begin
            chk(!saw_trig, "R9 no trigger on timeout", int'(saw_trig), 0);
          end else begin
            chk(prev_trig && !trig, "R10 done after trig falls", int'(prev_trig), 1);
            chk(win_len == WIN, "R5 window length", win_len, WIN);
            chk(g_cnt == 1, "R6 glitch count", g_cnt, 1);
            chk(g_pos == e.off + 1, "R6 R7 glitch position", g_pos, e.off + 1);
            chk(int'(pwr_code) == e.pw, "R8 R7 power code", int'(pwr_code), e.pw);
            chk(pwr_code >= 7'd10 && pwr_code <= 7'd100, "R8 power range", int'(pwr_code), 10);
          end
        end
        saw_trig = 1'b0;
      end
      prev_trig = trig;
    end
  end

  initial begin
    rst = 1'b1; run = 1'b0; mon_line = 1'b1;
    repeat (5) @(negedge clk);
    chk(tgt_rst_n && !trig && !glitch && !done && !tmo && pwr_code == 7'd0,
        "R1 reset state", int'({tgt_rst_n, trig, glitch, done, tmo}), 16);
    rst = 1'b0;
    begin
      bit quiet = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (!tgt_rst_n || trig || done || tmo) quiet = 1'b0;
      end
      chk(quiet, "R1 idle while run low", int'(quiet), 1);
    end
    run = 1'b1;
    run_exp(BLANK + 5,       1'b0, 1'b1, 1'b0); // R4 R6 normal
    run_exp(3,               1'b0, 1'b0, 1'b1); // R3 edge in blanking
    run_exp(BLANK + 2,       1'b1, 1'b1, 1'b0); // R5 extra edge in window
    run_exp(-1,              1'b0, 1'b0, 1'b0); // R9 no edge
    run_exp(BLANK - 2,       1'b0, 1'b1, 1'b0); // R3 first arming cycle
    run_exp(BLANK - 3,       1'b0, 1'b0, 1'b1); // R3 last blanking cycle
    run_exp(BLANK + TMO - 3, 1'b0, 1'b1, 1'b0); // R9 last cycle before timeout
    wait_release();
    run = 1'b0;                                  // R10 stop after this one
    repeat (BLANK + 10) @(negedge clk);
    mon_line = 1'b0; drop_cyc = cyc; push_hit();
    repeat (4) @(negedge clk); mon_line = 1'b1;
    wait_done();
    @(negedge clk);
    begin
      bit quiet = 1'b1;
      repeat (60) begin
        @(negedge clk);
        if (!tgt_rst_n || trig || done || glitch) quiet = 1'b0;
      end
      chk(quiet, "R10 idle after run cleared", int'(quiet), 1);
    end
    chk(q.size() == 0, "R10 all experiments completed", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule